// File: doc/BRIEF.md
# Automatic Xon/Xoff Transmit Inserter

This block sits between a UART channel's transmit FIFO and its transmit shift register. It decides, one transmit slot at a time, which character the shifter loads next. Normally that is the head of the transmit FIFO. When in-band flow control is enabled and the receive FIFO becomes nearly full, the block slips a stop character (Xoff) into the stream ahead of waiting data. Once the receive FIFO has drained far enough, it sends a resume character (Xon). The two fill marks, 240 and 16, give the decision hysteresis, so the block does not chatter around a single threshold.

A request that comes from the fill level is not latched. It is re-evaluated in every slot, so if the level returns to the middle band before a slot opens, nothing is sent. A flag records that a stop character is on the wire and has not yet been undone by a resume character. Turning the automatic mode off clears that flag, and no resume character is sent. The host can also force a resume or stop character through one-cycle command pulses. A kill pulse withdraws a queued forced character, but only while the automatic mode is off.

A character that has been handed to the shifter is never withdrawn. The output byte stays put until the next load. No interrupt is raised by any of this activity.

Top module: `xfc_inserter`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `sh_load`, `txf_pop`, `sh_ctrl`, `xoff_sent` and `host_pending` are 0.
- R2: With `auto_en`=1 and `xoff_sent`=0, an `rx_level` above 240 (241..255) makes the next open slot load `xoff_char` with `sh_ctrl`=1 and sets `xoff_sent`. A level of 240 or below sends no stop character.
- R3: With `auto_en`=1 and `xoff_sent`=1, an `rx_level` below 16 (0..15) makes the next open slot load `xon_char` with `sh_ctrl`=1 and clears `xoff_sent`. No stop character is repeated while `xoff_sent`=1, and levels 16..240 cause no control character.
- R4: An automatic request is re-evaluated in every slot. If the level is back inside 16..240 before the slot opens, no control character is sent, and the slot goes to FIFO data.
- R5: The slot priority is automatic control character first, then the host-forced character, then the transmit FIFO. A FIFO character that loses the slot is not popped and stays available for a later slot.
- R6: A load happens only in a cycle after `sh_ready` was sampled 1 and never in two consecutive cycles. `sh_data` and `sh_ctrl` hold their value between loads, whatever the other inputs do.
- R7: One clock after `auto_en` is 0, `xoff_sent` is 0, and re-enabling with a low level sends no resume character.
- R8: A `cmd_xon` or `cmd_xoff` pulse queues one forced character (`host_pending`=1). If both pulse together, `cmd_xoff` wins. The forced character is sent as `xon_char` or `xoff_char` with `sh_ctrl`=1 and leaves `xoff_sent` unchanged.
- R9: A `cmd_kill` pulse clears a queued forced character when `auto_en`=0. With `auto_en`=1 it is ignored and the forced character is still sent.
- R10: `txf_pop` pulses in the same cycle as `sh_load` exactly when the loaded byte came from the transmit FIFO (`sh_ctrl`=0), and only if `txf_valid` was 1 in the deciding cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| auto_en | input | 1 | Automatic in-band flow control enable |
| rx_level | input | 8 | Receive FIFO fill level, 0..255 |
| xon_char | input | 8 | Resume character value |
| xoff_char | input | 8 | Stop character value |
| cmd_xon | input | 1 | Host pulse: queue a forced resume character |
| cmd_xoff | input | 1 | Host pulse: queue a forced stop character |
| cmd_kill | input | 1 | Host pulse: drop the queued forced character (automatic mode off only) |
| txf_valid | input | 1 | Transmit FIFO head is valid |
| txf_data | input | 8 | Transmit FIFO head byte |
| txf_pop | output | 1 | Pop the transmit FIFO head |
| sh_ready | input | 1 | Shift register idle and able to take a byte |
| sh_load | output | 1 | Load `sh_data` into the shift register |
| sh_data | output | 8 | Byte for the shift register |
| sh_ctrl | output | 1 | Loaded byte is a flow-control character |
| xoff_sent | output | 1 | A stop character was sent and not yet undone |
| host_pending | output | 1 | A host-forced character is queued |

## Verification
Each result has a fixed latency, and the checks are timed to it.
- A change of `rx_level` reaches the slot decision one clock later, through the level flags. The bench therefore holds each level for three clocks with `sh_ready` low before it opens a slot.
- A host pulse is queued at the next edge, and `host_pending` is checked on the negative edge after that.
- A slot opened by raising `sh_ready` at a negative edge shows `sh_load`, `sh_data`, `sh_ctrl`, `txf_pop` and the new `xoff_sent` after the following rising edge. The bench samples them on the next negative edge, then checks that the following cycle carries no load.
- In the burst test `sh_ready` is held high, and the bench samples every cycle to confirm that loads come every second cycle.

// File: rtl/xfc_pkg.sv
package xfc_pkg;
  // Source selected for one transmit slot, highest priority first after NONE
  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_XOFF = 3'd1,
    SRC_XON  = 3'd2,
    SRC_HOST = 3'd3,
    SRC_FIFO = 3'd4
  } src_e;
endpackage

// File: rtl/xfc_level_watch.sv
module xfc_level_watch #(
  parameter int LVL_W   = 8,
  parameter int HI_MARK = 240,
  parameter int LO_MARK = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] rx_level,
  output logic             above_hi,
  output logic             below_lo
);
  localparam logic [LVL_W-1:0] HI_V = LVL_W'(HI_MARK);
  localparam logic [LVL_W-1:0] LO_V = LVL_W'(LO_MARK);

  always_ff @(posedge clk) begin
    if (rst) begin
      above_hi <= 1'b0;
      below_lo <= 1'b0;
    end else begin
      above_hi <= (rx_level > HI_V);
      below_lo <= (rx_level < LO_V);
    end
  end
endmodule

// File: rtl/xfc_host_queue.sv
module xfc_host_queue (
  input  logic clk,
  input  logic rst,
  input  logic auto_en,
  input  logic cmd_xon,
  input  logic cmd_xoff,
  input  logic cmd_kill,
  input  logic taken,
  output logic pending,
  output logic is_xoff
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      is_xoff <= 1'b0;
    end else if (cmd_xoff) begin
      pending <= 1'b1;
      is_xoff <= 1'b1;
    end else if (cmd_xon) begin
      pending <= 1'b1;
      is_xoff <= 1'b0;
    end else if (cmd_kill && !auto_en) begin
      pending <= 1'b0;
    end else if (taken) begin
      pending <= 1'b0;
    end
  end
endmodule

// File: rtl/xfc_slot_arb.sv
module xfc_slot_arb
  import xfc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              auto_en,
  input  logic              above_hi,
  input  logic              below_lo,
  input  logic              host_pend,
  input  logic              host_is_xoff,
  input  logic [DATA_W-1:0] xon_char,
  input  logic [DATA_W-1:0] xoff_char,
  input  logic              txf_valid,
  input  logic [DATA_W-1:0] txf_data,
  input  logic              sh_ready,
  output logic              host_taken,
  output logic              txf_pop,
  output logic              sh_load,
  output logic [DATA_W-1:0] sh_data,
  output logic              sh_ctrl,
  output logic              xoff_sent
);
  src_e              sel;
  logic [DATA_W-1:0] sel_byte;
  logic              slot_open;

  // A slot is open when the shifter is idle and no load left last cycle
  assign slot_open = sh_ready && !sh_load;

  always_comb begin
    sel = SRC_NONE;
    if (slot_open) begin
      if (auto_en && above_hi && !xoff_sent)     sel = SRC_XOFF;
      else if (auto_en && below_lo && xoff_sent) sel = SRC_XON;
      else if (host_pend)                        sel = SRC_HOST;
      else if (txf_valid)                        sel = SRC_FIFO;
    end
  end

  always_comb begin
    case (sel)
      SRC_XOFF: sel_byte = xoff_char;
      SRC_XON:  sel_byte = xon_char;
      SRC_HOST: sel_byte = host_is_xoff ? xoff_char : xon_char;
      default:  sel_byte = txf_data;
    endcase
  end

  assign host_taken = (sel == SRC_HOST);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_load   <= 1'b0;
      sh_data   <= '0;
      sh_ctrl   <= 1'b0;
      txf_pop   <= 1'b0;
      xoff_sent <= 1'b0;
    end else begin
      sh_load <= (sel != SRC_NONE);
      txf_pop <= (sel == SRC_FIFO);
      if (sel != SRC_NONE) begin
        sh_data <= sel_byte;
        sh_ctrl <= (sel != SRC_FIFO);
      end
      if (!auto_en)            xoff_sent <= 1'b0;
      else if (sel == SRC_XOFF) xoff_sent <= 1'b1;
      else if (sel == SRC_XON)  xoff_sent <= 1'b0;
    end
  end
endmodule

// File: rtl/xfc_inserter.sv
module xfc_inserter #(
  parameter int DATA_W  = 8,
  parameter int LVL_W   = 8,
  parameter int HI_MARK = 240,
  parameter int LO_MARK = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              auto_en,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic [DATA_W-1:0] xon_char,
  input  logic [DATA_W-1:0] xoff_char,
  input  logic              cmd_xon,
  input  logic              cmd_xoff,
  input  logic              cmd_kill,
  input  logic              txf_valid,
  input  logic [DATA_W-1:0] txf_data,
  output logic              txf_pop,
  input  logic              sh_ready,
  output logic              sh_load,
  output logic [DATA_W-1:0] sh_data,
  output logic              sh_ctrl,
  output logic              xoff_sent,
  output logic              host_pending
);
  logic above_hi, below_lo;
  logic host_is_xoff, host_taken;

  xfc_level_watch #(.LVL_W(LVL_W), .HI_MARK(HI_MARK), .LO_MARK(LO_MARK)) u_lvl (
    .clk(clk), .rst(rst), .rx_level(rx_level),
    .above_hi(above_hi), .below_lo(below_lo)
  );

  xfc_host_queue u_host (
    .clk(clk), .rst(rst), .auto_en(auto_en),
    .cmd_xon(cmd_xon), .cmd_xoff(cmd_xoff), .cmd_kill(cmd_kill),
    .taken(host_taken), .pending(host_pending), .is_xoff(host_is_xoff)
  );

  xfc_slot_arb #(.DATA_W(DATA_W)) u_arb (
    .clk(clk), .rst(rst), .auto_en(auto_en),
    .above_hi(above_hi), .below_lo(below_lo),
    .host_pend(host_pending), .host_is_xoff(host_is_xoff),
    .xon_char(xon_char), .xoff_char(xoff_char),
    .txf_valid(txf_valid), .txf_data(txf_data), .sh_ready(sh_ready),
    .host_taken(host_taken), .txf_pop(txf_pop),
    .sh_load(sh_load), .sh_data(sh_data), .sh_ctrl(sh_ctrl),
    .xoff_sent(xoff_sent)
  );
endmodule

// File: rtl/xfc_inserter_chk.sv
module xfc_inserter_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              auto_en,
  input logic [DATA_W-1:0] xon_char,
  input logic [DATA_W-1:0] xoff_char,
  input logic              txf_valid,
  input logic              txf_pop,
  input logic              sh_ready,
  input logic              sh_load,
  input logic [DATA_W-1:0] sh_data,
  input logic              sh_ctrl,
  input logic              xoff_sent
);
  assert_one_load_per_slot_R6: assert property (@(posedge clk) disable iff (rst)
    sh_load |=> !sh_load);

  assert_load_needs_ready_R6: assert property (@(posedge clk) disable iff (rst)
    sh_load |-> $past(sh_ready));

  assert_hold_between_loads_R6: assert property (@(posedge clk) disable iff (rst)
    !sh_load |-> ($stable(sh_data) && $stable(sh_ctrl)));

  assert_pop_with_data_load_R10: assert property (@(posedge clk) disable iff (rst)
    txf_pop |-> (sh_load && !sh_ctrl && $past(txf_valid)));

  assert_flag_set_by_stop_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(xoff_sent) |-> (sh_load && sh_ctrl && sh_data == $past(xoff_char)));

  assert_flag_clear_by_resume_R3: assert property (@(posedge clk) disable iff (rst)
    ($fell(xoff_sent) && $past(auto_en)) |-> (sh_load && sh_ctrl && sh_data == $past(xon_char)));

  assert_flag_off_when_disabled_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(auto_en) |-> !xoff_sent);
endmodule

bind xfc_inserter xfc_inserter_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .auto_en(auto_en),
  .xon_char(xon_char), .xoff_char(xoff_char),
  .txf_valid(txf_valid), .txf_pop(txf_pop), .sh_ready(sh_ready),
  .sh_load(sh_load), .sh_data(sh_data), .sh_ctrl(sh_ctrl),
  .xoff_sent(xoff_sent)
);

// File: tb/test_xfc_inserter.sv
`timescale 1ns/1ps
module test_xfc_inserter;
  localparam logic [7:0] XON  = 8'h11;
  localparam logic [7:0] XOFF = 8'h13;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic       rst = 1'b1, auto_en = 1'b0;
  logic [7:0] rx_level = 8'd0, xon_char = XON, xoff_char = XOFF;
  logic       cmd_xon = 1'b0, cmd_xoff = 1'b0, cmd_kill = 1'b0;
  logic       txf_valid = 1'b0, sh_ready = 1'b0;
  logic [7:0] txf_data = 8'd0;
  logic       txf_pop, sh_load, sh_ctrl, xoff_sent, host_pending;
  logic [7:0] sh_data;

  int checks = 0;
  int errors = 0;

  xfc_inserter i_xfc_inserter (
    .clk(clk), .rst(rst), .auto_en(auto_en), .rx_level(rx_level),
    .xon_char(xon_char), .xoff_char(xoff_char),
    .cmd_xon(cmd_xon), .cmd_xoff(cmd_xoff), .cmd_kill(cmd_kill),
    .txf_valid(txf_valid), .txf_data(txf_data), .txf_pop(txf_pop),
    .sh_ready(sh_ready), .sh_load(sh_load), .sh_data(sh_data),
    .sh_ctrl(sh_ctrl), .xoff_sent(xoff_sent), .host_pending(host_pending)
  );

  typedef struct packed {
    logic [7:0] lvl;
    logic       fv;
    logic [7:0] fd;
    logic [1:0] cmd;   // 0 none, 1 host resume, 2 host stop, 3 kill
    logic       en;
    logic       eload;
    logic [7:0] edata;
    logic       ectrl;
    logic       exs;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{8'd100, 1'b1, 8'h41, 2'd0, 1'b1, 1'b1, 8'h41, 1'b0, 1'b0, 4'd10}, // R10 plain data
    '{8'd241, 1'b1, 8'h42, 2'd0, 1'b1, 1'b1, XOFF,  1'b1, 1'b1, 4'd5 }, // R5/R2 stop beats data
    '{8'd250, 1'b1, 8'h42, 2'd0, 1'b1, 1'b1, 8'h42, 1'b0, 1'b1, 4'd3 }, // R3 no repeat, R5 data kept
    '{8'd240, 1'b0, 8'h00, 2'd0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 4'd2 }, // R2 boundary 240
    '{8'd16,  1'b1, 8'h44, 2'd0, 1'b1, 1'b1, 8'h44, 1'b0, 1'b1, 4'd3 }, // R3 boundary 16
    '{8'd15,  1'b1, 8'h45, 2'd0, 1'b1, 1'b1, XON,   1'b1, 1'b0, 4'd3 }, // R3 resume
    '{8'd5,   1'b0, 8'h00, 2'd0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 4'd3 }, // R3 single resume
    '{8'd100, 1'b1, 8'h46, 2'd2, 1'b1, 1'b1, XOFF,  1'b1, 1'b0, 4'd8 }, // R8 host stop
    '{8'd100, 1'b0, 8'h00, 2'd1, 1'b0, 1'b1, XON,   1'b1, 1'b0, 4'd8 }, // R8 host resume
    '{8'd100, 1'b1, 8'h47, 2'd3, 1'b0, 1'b1, 8'h47, 1'b0, 1'b0, 4'd9 }, // R9 kill, nothing queued
    '{8'd241, 1'b1, 8'h48, 2'd0, 1'b0, 1'b1, 8'h48, 1'b0, 1'b0, 4'd7 }, // R7 auto off, no stop
    '{8'd241, 1'b0, 8'h00, 2'd0, 1'b1, 1'b1, XOFF,  1'b1, 1'b1, 4'd2 }  // R2 stop
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [1:0] c);
    @(negedge clk);
    cmd_xon  = (c == 2'd1);
    cmd_xoff = (c == 2'd2);
    cmd_kill = (c == 2'd3);
    @(negedge clk);
    cmd_xon = 1'b0; cmd_xoff = 1'b0; cmd_kill = 1'b0;
  endtask

  // Opens one slot; returns the outputs seen after the deciding edge
  task automatic slot(output logic ld, output logic [7:0] d, output logic c,
                      output logic pop, output logic xs);
    sh_ready = 1'b1;
    @(negedge clk);
    ld = sh_load; d = sh_data; c = sh_ctrl; pop = txf_pop; xs = xoff_sent;
    sh_ready = 1'b0;
  endtask

  logic       ld, c, pop, xs;
  logic [7:0] d;
  bit         done = 1'b0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 load in reset", sh_load, 0);
    chk("R1 flag in reset", xoff_sent, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 load", sh_load, 0);
    chk("R1 pop", txf_pop, 0);
    chk("R1 ctrl", sh_ctrl, 0);
    chk("R1 flag", xoff_sent, 0);
    chk("R1 host", host_pending, 0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d row%0d", VEC[i].req, i);
      @(negedge clk);
      rx_level = VEC[i].lvl; txf_valid = VEC[i].fv; txf_data = VEC[i].fd;
      auto_en = VEC[i].en; sh_ready = 1'b0;
      if (VEC[i].cmd != 2'd0) pulse(VEC[i].cmd);
      repeat (3) @(negedge clk);
      slot(ld, d, c, pop, xs);
      chk({tag, " load"}, ld, VEC[i].eload);
      if (VEC[i].eload) begin
        chk({tag, " data"}, d, VEC[i].edata);
        chk({tag, " ctrl"}, c, VEC[i].ectrl);
      end
      chk({tag, " pop"}, pop, VEC[i].eload && !VEC[i].ectrl);
      chk({tag, " flag"}, xs, VEC[i].exs);
      @(negedge clk);
      chk({tag, " R6 single load"}, sh_load, 0);
    end

    // R7: disabling clears the flag, re-enabling sends no resume
    txf_valid = 1'b0; auto_en = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7 flag cleared", xoff_sent, 0);
    auto_en = 1'b1; rx_level = 8'd5;
    repeat (3) @(negedge clk);
    slot(ld, d, c, pop, xs);
    chk("R7 no automatic resume", ld, 0);
    @(negedge clk);

    // R4: stop request withdrawn before the slot opens
    rx_level = 8'd245;
    repeat (3) @(negedge clk);
    rx_level = 8'd200; txf_valid = 1'b1; txf_data = 8'h50;
    repeat (3) @(negedge clk);
    slot(ld, d, c, pop, xs);
    chk("R4 data instead of stop", d, 8'h50);
    chk("R4 not ctrl", c, 0);
    chk("R4 flag stays clear", xs, 0);
    txf_valid = 1'b0;
    @(negedge clk);

    // R9: kill drops queued host stop while auto is off
    auto_en = 1'b0; rx_level = 8'd100;
    pulse(2'd2);
    chk("R8 host queued", host_pending, 1);
    pulse(2'd3);
    chk("R9 kill clears queue", host_pending, 0);
    slot(ld, d, c, pop, xs);
    chk("R9 nothing sent after kill", ld, 0);
    @(negedge clk);
    // R9: kill ignored with auto on
    auto_en = 1'b1;
    pulse(2'd1);
    pulse(2'd3);
    chk("R9 kill ignored in auto", host_pending, 1);
    slot(ld, d, c, pop, xs);
    chk("R9 host resume sent", d, XON);
    chk("R9 host resume ctrl", c, 1);
    chk("R8 host leaves flag", xs, 0);

    // R6: loaded byte held while inputs move
    xon_char = 8'h99; rx_level = 8'd250;
    repeat (4) @(negedge clk);
    chk("R6 data held", sh_data, XON);
    chk("R6 no load while busy", sh_load, 0);
    xon_char = XON;
    slot(ld, d, c, pop, xs);
    chk("R2 stop after level rise", d, XOFF);
    chk("R2 flag set", xs, 1);
    @(negedge clk);

    // R6/R10: ready held high, loads every second cycle
    rx_level = 8'd100; txf_valid = 1'b1; txf_data = 8'h60;
    @(negedge clk);
    begin
      int loads, pops;
      loads = 0; pops = 0;
      sh_ready = 1'b1;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        loads += int'(sh_load);
        pops  += int'(txf_pop);
      end
      sh_ready = 1'b0;
      chk("R6 burst load count", loads, 3);
      chk("R10 burst pop count", pops, 3);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule